// File: doc/BRIEF.md
# Programmable Horizontal Line Timer

This block generates the horizontal part of a video raster. A pixel-clock counter runs through each line. Four line settings decide where the sync pulse and the active picture fall on that line: the line length, the sync width, the start-of-picture offset and the end-of-picture offset. Each setting is 16 bits wide. Both picture offsets are measured from the first clock of the sync pulse, which is count zero.

A 6-bit format code picks the settings. The code comes from external pins, or from a host register when a host control bit is set. The block has a small built-in table of fixed formats, and the host cannot change those settings. One code, 62, is the custom format: while it is selected, the host can write all four settings. Any change of code and any accepted write take effect at the next line boundary, so a line already in progress is never shortened or cut. The host reaches the registers through a plain bus with an 8-bit address, 16-bit data and a one-cycle write strobe. Reads are combinational and return the settings of the format selected at that moment.

Top module: `htg_top`

## Requirements
- R1: The line counter starts at 0 after reset, counts up by one per clock, and wraps to 0 after the clock in which count+1 reaches the line length. The line therefore lasts exactly that many clocks.
- R2: `hsync_o` is high while the count is below the sync width, so the pulse starts at the first clock of each line.
- R3: `active_o` is high while the count is greater than or equal to the start-of-picture offset and below the end-of-picture offset.
- R4: `sav_o` is high only while the count equals the start-of-picture offset. `eav_o` is high only while the count equals the end-of-picture offset.
- R5: Control register bit 0, at address 0x00, chooses the code source. When the bit is 1, the host code register at address 0x01, bits 5:0, is used and the pins are ignored. When the bit is 0, the pins are used.
- R6: The settings are at these addresses: line length 0x02, sync width 0x03, start offset 0x04, end offset 0x05. A write to these addresses is stored only if the code in effect at that moment is 62. Under any other code the write has no effect.
- R7: The fixed formats, as (length, sync, start, end), are: code 0 = (20,3,5,17), code 1 = (32,4,8,28), code 2 = (12,2,3,10). Any code other than 0, 1, 2 and 62 uses the code 0 format. The custom settings reset to the code 0 values.
- R8: A change of the selected settings takes effect only at the next line wrap. This covers a change of code and a custom write. The line in progress keeps its length and edges.
- R9: After reset the control bit and the host code are 0. Unused bits of the control and code registers read as 0, and writes to them are not stored.
- R10: A read returns the control bit, the host code, or the setting of the currently selected format for addresses 0x00 to 0x05. Any other address reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fmt_pins_i | input | 6 | Format code from external pins |
| host_addr_i | input | 8 | Host register address |
| host_wr_i | input | 1 | One-cycle host write strobe |
| host_wdata_i | input | 16 | Host write data |
| host_rdata_o | output | 16 | Host read data |
| hsync_o | output | 1 | Horizontal sync level |
| active_o | output | 1 | Active picture flag |
| sav_o | output | 1 | Start-of-picture strobe |
| eav_o | output | 1 | End-of-picture strobe |

## Verification
The bench first runs each fixed format unchanged from the pins. This shows whether the table entries and the three comparisons for sync, picture and strobes are placed correctly. It then switches the code in the middle of a line. The time between sync rises must keep the old length for one more line, and this separates loading at the boundary from loading at once. Writes are tried both under a fixed code and under code 62, with the source switched between pins and host. This shows whether the write gate and the source select follow the code actually in effect. A long seeded random phase mixes codes, short custom lines and writes to all registers, and compares every output and every read with a cycle model kept in the bench.

// File: rtl/htg_pkg.sv
package htg_pkg;
  localparam int DW = 16;
  localparam int CW = 6;

  typedef struct packed {
    logic [DW-1:0] period;
    logic [DW-1:0] hs_width;
    logic [DW-1:0] sav_off;
    logic [DW-1:0] eav_off;
  } line_par_t;

  localparam line_par_t FMT0 = '{period: 16'd20, hs_width: 16'd3, sav_off: 16'd5,  eav_off: 16'd17};
  localparam line_par_t FMT1 = '{period: 16'd32, hs_width: 16'd4, sav_off: 16'd8,  eav_off: 16'd28};
  localparam line_par_t FMT2 = '{period: 16'd12, hs_width: 16'd2, sav_off: 16'd3,  eav_off: 16'd10};

  // Register addresses used by the host bus.
  localparam logic [7:0] A_CTRL = 8'h00;
  localparam logic [7:0] A_CODE = 8'h01;
  localparam logic [7:0] A_PER  = 8'h02;
  localparam logic [7:0] A_HSW  = 8'h03;
  localparam logic [7:0] A_SAV  = 8'h04;
  localparam logic [7:0] A_EAV  = 8'h05;
endpackage

// File: rtl/htg_preset_rom.sv
module htg_preset_rom
  import htg_pkg::*;
#(
  parameter int CODE_W = CW
) (
  input  logic [CODE_W-1:0] code_i,
  output line_par_t         par_o
);
  always_comb begin
    case (code_i)
      CODE_W'(0): par_o = FMT0;
      CODE_W'(1): par_o = FMT1;
      CODE_W'(2): par_o = FMT2;
      default:    par_o = FMT0;
    endcase
  end
endmodule

// File: rtl/htg_host_regs.sv
module htg_host_regs
  import htg_pkg::*;
#(
  parameter int          CODE_W = CW,
  parameter int          ADDR_W = 8,
  parameter logic [5:0]  CUSTOM = 6'd62
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CODE_W-1:0] pins_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wr_i,
  input  logic [DW-1:0]     wdata_i,
  output logic [DW-1:0]     rdata_o,
  output line_par_t         sel_o,
  output logic [CODE_W-1:0] code_o,
  output line_par_t         cust_o
);
  logic              ctrl_q, ctrl_d, ctrl_en;
  logic [CODE_W-1:0] hcode_q, hcode_d;
  logic              hcode_en;
  line_par_t         cust_q, cust_d;
  logic              cust_en;
  logic              is_custom;
  line_par_t         rom_par;

  assign code_o    = ctrl_q ? hcode_q : pins_i;
  assign is_custom = (code_o == CODE_W'(CUSTOM));

  htg_preset_rom #(.CODE_W(CODE_W)) u_rom (
    .code_i (code_o),
    .par_o  (rom_par)
  );

  assign sel_o  = is_custom ? cust_q : rom_par;
  assign cust_o = cust_q;

  // Next-state logic
  always_comb begin
    ctrl_en  = wr_i && (addr_i == ADDR_W'(A_CTRL));
    ctrl_d   = wdata_i[0];
    hcode_en = wr_i && (addr_i == ADDR_W'(A_CODE));
    hcode_d  = wdata_i[CODE_W-1:0];
    cust_en  = wr_i && is_custom;
    cust_d   = cust_q;
    if (addr_i == ADDR_W'(A_PER))      cust_d.period   = wdata_i;
    else if (addr_i == ADDR_W'(A_HSW)) cust_d.hs_width = wdata_i;
    else if (addr_i == ADDR_W'(A_SAV)) cust_d.sav_off  = wdata_i;
    else if (addr_i == ADDR_W'(A_EAV)) cust_d.eav_off  = wdata_i;
    else                               cust_en         = 1'b0;
  end

  // Registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q  <= 1'b0;
      hcode_q <= '0;
      cust_q  <= FMT0;
    end else begin
      if (ctrl_en)  ctrl_q  <= ctrl_d;
      if (hcode_en) hcode_q <= hcode_d;
      if (cust_en)  cust_q  <= cust_d;
    end
  end

  // Read mux
  always_comb begin
    rdata_o = '0;
    case (addr_i)
      ADDR_W'(A_CTRL): rdata_o = {{(DW-1){1'b0}}, ctrl_q};
      ADDR_W'(A_CODE): rdata_o = {{(DW-CODE_W){1'b0}}, hcode_q};
      ADDR_W'(A_PER):  rdata_o = sel_o.period;
      ADDR_W'(A_HSW):  rdata_o = sel_o.hs_width;
      ADDR_W'(A_SAV):  rdata_o = sel_o.sav_off;
      ADDR_W'(A_EAV):  rdata_o = sel_o.eav_off;
      default:         rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/htg_line_counter.sv
module htg_line_counter
  import htg_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  line_par_t     sel_i,
  output logic [DW-1:0] cnt_o,
  output line_par_t     lat_o,
  output logic          wrap_o,
  output logic          hsync_o,
  output logic          active_o,
  output logic          sav_o,
  output logic          eav_o
);
  logic [DW-1:0] cnt_q, cnt_d;
  line_par_t     lat_q, lat_d;
  logic          lat_en;

  assign wrap_o = ({1'b0, cnt_q} + (DW+1)'(1)) >= {1'b0, lat_q.period};

  always_comb begin
    lat_en = wrap_o;
    lat_d  = sel_i;
    cnt_d  = wrap_o ? '0 : cnt_q + DW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      lat_q <= FMT0;
    end else begin
      cnt_q <= cnt_d;
      if (lat_en) lat_q <= lat_d;
    end
  end

  assign cnt_o    = cnt_q;
  assign lat_o    = lat_q;
  assign hsync_o  = cnt_q < lat_q.hs_width;
  assign active_o = (cnt_q >= lat_q.sav_off) && (cnt_q < lat_q.eav_off);
  assign sav_o    = cnt_q == lat_q.sav_off;
  assign eav_o    = cnt_q == lat_q.eav_off;
endmodule

// File: rtl/htg_top.sv
module htg_top
  import htg_pkg::*;
#(
  parameter int         CODE_W = CW,
  parameter int         ADDR_W = 8,
  parameter logic [5:0] CUSTOM = 6'd62
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CODE_W-1:0] fmt_pins_i,
  input  logic [ADDR_W-1:0] host_addr_i,
  input  logic              host_wr_i,
  input  logic [DW-1:0]     host_wdata_i,
  output logic [DW-1:0]     host_rdata_o,
  output logic              hsync_o,
  output logic              active_o,
  output logic              sav_o,
  output logic              eav_o
);
  logic              rst_s1_q, rst_sync_n;
  line_par_t         sel_w, lat_w, cust_w;
  logic [CODE_W-1:0] code_w;
  logic [DW-1:0]     cnt_w;
  logic              wrap_w;

  // Reset: asserted asynchronously, released on a clock edge.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_s1_q   <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_s1_q   <= 1'b1;
      rst_sync_n <= rst_s1_q;
    end
  end

  htg_host_regs #(.CODE_W(CODE_W), .ADDR_W(ADDR_W), .CUSTOM(CUSTOM)) u_regs (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .pins_i  (fmt_pins_i),
    .addr_i  (host_addr_i),
    .wr_i    (host_wr_i),
    .wdata_i (host_wdata_i),
    .rdata_o (host_rdata_o),
    .sel_o   (sel_w),
    .code_o  (code_w),
    .cust_o  (cust_w)
  );

  htg_line_counter u_cnt (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .sel_i    (sel_w),
    .cnt_o    (cnt_w),
    .lat_o    (lat_w),
    .wrap_o   (wrap_w),
    .hsync_o  (hsync_o),
    .active_o (active_o),
    .sav_o    (sav_o),
    .eav_o    (eav_o)
  );
endmodule

// File: rtl/htg_checker.sv
module htg_checker
  import htg_pkg::*;
#(
  parameter int         CODE_W = CW,
  parameter int         ADDR_W = 8,
  parameter logic [5:0] CUSTOM = 6'd62
) (
  input logic              clk,
  input logic              rst_n,
  input logic [DW-1:0]     cnt,
  input line_par_t         lat,
  input line_par_t         cust,
  input logic [CODE_W-1:0] code,
  input logic              wr,
  input logic [ADDR_W-1:0] addr,
  input logic [DW-1:0]     rdata,
  input logic              hsync,
  input logic              active,
  input logic              sav
);
  logic wrap_c;
  assign wrap_c = ({1'b0, cnt} + (DW+1)'(1)) >= {1'b0, lat.period};

  assert_wrap_to_zero_R1: assert property (@(posedge clk) disable iff (!rst_n)
    wrap_c |=> cnt == '0);

  assert_count_step_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !wrap_c |=> cnt == $past(cnt) + DW'(1));

  assert_sync_at_line_start_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt == '0 && lat.hs_width != '0) |-> hsync);

  assert_sav_opens_active_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (sav && lat.sav_off < lat.eav_off) |-> active);

  assert_params_held_in_line_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !wrap_c |=> $stable(lat));

  assert_fixed_write_ignored_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && code != CODE_W'(CUSTOM)) |=> $stable(cust));

  assert_ctrl_reserved_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (addr == ADDR_W'(A_CTRL)) |-> rdata[DW-1:1] == '0);
endmodule

bind htg_top htg_checker #(.CODE_W(CODE_W), .ADDR_W(ADDR_W), .CUSTOM(CUSTOM)) u_chk (
  .clk    (clk),
  .rst_n  (rst_sync_n),
  .cnt    (cnt_w),
  .lat    (lat_w),
  .cust   (cust_w),
  .code   (code_w),
  .wr     (host_wr_i),
  .addr   (host_addr_i),
  .rdata  (host_rdata_o),
  .hsync  (hsync_o),
  .active (active_o),
  .sav    (sav_o)
);

// File: tb/htg_tb.sv
`timescale 1ns/1ps
module htg_top_tb_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [5:0]  pins;
  logic [7:0]  addr;
  logic        wr;
  logic [15:0] wdata;
  logic [15:0] rdata;
  logic        hsync, active, sav, eav;

  int n_chk = 0, n_err = 0;

  always #10 clk = ~clk;

  htg_top dut_i (
    .clk(clk), .rst_n(rst_n), .fmt_pins_i(pins), .host_addr_i(addr),
    .host_wr_i(wr), .host_wdata_i(wdata), .host_rdata_o(rdata),
    .hsync_o(hsync), .active_o(active), .sav_o(sav), .eav_o(eav)
  );

  // Bench model state: index 0 length, 1 sync, 2 start, 3 end
  int m_cnt;
  int m_lat [4];
  int m_cust[4];
  int m_ctrl, m_hcode;
  int since_rise, last_len, prev_hs;

  function automatic int fmt_val(int code, int idx);
    int t0[4] = '{20, 3, 5, 17};
    int t1[4] = '{32, 4, 8, 28};
    int t2[4] = '{12, 2, 3, 10};
    if (code == 1) return t1[idx];
    if (code == 2) return t2[idx];
    return t0[idx];
  endfunction

  function automatic int eff_code(int p);
    return (m_ctrl != 0) ? m_hcode : p;
  endfunction

  function automatic int sel_val(int p, int idx);
    int c = eff_code(p);
    return (c == 62) ? m_cust[idx] : fmt_val(c, idx);
  endfunction

  function automatic int exp_read(int p, int a);
    if (a == 0) return m_ctrl;
    if (a == 1) return m_hcode;
    if (a >= 2 && a <= 5) return sel_val(p, a - 2);
    return 0;
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic model_reset();
    m_cnt = 0; m_ctrl = 0; m_hcode = 0;
    for (int i = 0; i < 4; i++) begin
      m_lat[i]  = fmt_val(0, i);
      m_cust[i] = fmt_val(0, i);
    end
    since_rise = 0; last_len = 0; prev_hs = 0;
  endtask

  // Runs at a falling edge: check outputs, drive next inputs, advance the model.
  task automatic cycle(input int p, input bit w, input int a, input int d);
    int c_now, sel[4];
    bit wrapped;
    chk(hsync == (m_cnt < m_lat[1]), "R2 hsync", hsync, m_cnt < m_lat[1]);
    chk(active == (m_cnt >= m_lat[2] && m_cnt < m_lat[3]), "R3 active", active,
        m_cnt >= m_lat[2] && m_cnt < m_lat[3]);
    chk(sav == (m_cnt == m_lat[2]), "R4 sav", sav, m_cnt == m_lat[2]);
    chk(eav == (m_cnt == m_lat[3]), "R4 eav", eav, m_cnt == m_lat[3]);
    since_rise++;
    if (hsync && prev_hs == 0) begin
      last_len = since_rise;
      since_rise = 0;
    end
    prev_hs = hsync;
    pins = 6'(p); wr = w; addr = 8'(a); wdata = 16'(d);
    #1;
    chk(rdata == 16'(exp_read(p, a)), "R10 read", rdata, exp_read(p, a));
    c_now = eff_code(p);
    for (int i = 0; i < 4; i++) sel[i] = sel_val(p, i);
    wrapped = (m_cnt + 1 >= m_lat[0]);
    if (wrapped) begin
      m_cnt = 0;
      for (int i = 0; i < 4; i++) m_lat[i] = sel[i];
    end else m_cnt++;
    if (w) begin
      if (a == 0) m_ctrl = d & 1;
      else if (a == 1) m_hcode = d & 63;
      else if (a >= 2 && a <= 5 && c_now == 62) m_cust[a - 2] = d & 16'hffff;
    end
    @(negedge clk);
  endtask

  task automatic run_to_rise(input int p);
    int guard = 0;
    cycle(p, 0, 2, 0);
    while (since_rise != 0 && guard < 200) begin
      cycle(p, 0, 2, 0);
      guard++;
    end
  endtask

  initial begin
    int p, a, d, r;
    rst_n = 1'b0; pins = 6'd0; addr = 8'd0; wr = 1'b0; wdata = 16'd0;
    model_reset();
    void'($urandom(32'h2bad5eed));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk); @(negedge clk);

    // R9: reset values
    addr = 8'h00; #1; chk(rdata == 16'd0, "R9 ctrl reset", rdata, 0);
    addr = 8'h01; #1; chk(rdata == 16'd0, "R9 code reset", rdata, 0);
    // R7: code 0 table entry visible at reset
    addr = 8'h02; #1; chk(rdata == 16'd20, "R7 fmt0 length", rdata, 20);
    addr = 8'h05; #1; chk(rdata == 16'd17, "R7 fmt0 end", rdata, 17);
    // R1: first line starts at count 0
    chk(hsync == 1'b1, "R1 line start after reset", hsync, 1);

    repeat (60) cycle(0, 0, 3, 0);

    // R7: code 1 selected by pins
    cycle(1, 0, 2, 0);
    chk(rdata == 16'd32, "R7 fmt1 length", rdata, 32);
    run_to_rise(1); run_to_rise(1); run_to_rise(1);
    chk(last_len == 32, "R1 line length fmt1", last_len, 32);

    // R8: switch mid-line; old line keeps its length
    repeat (10) cycle(1, 0, 0, 0);
    run_to_rise(0);
    chk(last_len == 32, "R8 line in progress kept", last_len, 32);
    run_to_rise(0);
    chk(last_len == 20, "R8 new length after wrap", last_len, 20);

    // R7: unknown code falls back to code 0
    cycle(5, 0, 4, 0);
    chk(rdata == 16'd5, "R7 fallback start", rdata, 5);

    // R6: write under a fixed code is dropped
    cycle(1, 1, 2, 99);
    cycle(1, 0, 2, 0);
    chk(rdata == 16'd32, "R6 fixed write ignored", rdata, 32);
    cycle(62, 0, 2, 0);
    chk(rdata == 16'd20, "R6 custom unchanged by fixed write", rdata, 20);

    // R6: custom writes accepted
    cycle(62, 1, 2, 24);
    cycle(62, 1, 3, 6);
    cycle(62, 1, 4, 9);
    cycle(62, 1, 5, 21);
    cycle(62, 0, 2, 0);
    chk(rdata == 16'd24, "R6 custom length stored", rdata, 24);
    run_to_rise(62); run_to_rise(62); run_to_rise(62);
    chk(last_len == 24, "R1 custom line length", last_len, 24);

    // R5: host source overrides pins
    cycle(62, 1, 1, 2);
    cycle(62, 1, 0, 1);
    cycle(62, 0, 2, 0);
    chk(rdata == 16'd12, "R5 host code used", rdata, 12);
    cycle(1, 0, 3, 0);
    chk(rdata == 16'd2, "R5 pins ignored", rdata, 2);
    run_to_rise(7); run_to_rise(7); run_to_rise(7);
    chk(last_len == 12, "R5 host format on line", last_len, 12);

    // R9: reserved bits
    cycle(0, 1, 0, 16'hfffe);
    cycle(0, 0, 0, 0);
    chk(rdata == 16'd0, "R9 ctrl reserved", rdata, 0);
    cycle(0, 1, 1, 16'hffff);
    cycle(0, 0, 1, 0);
    chk(rdata == 16'h003f, "R9 code reserved", rdata, 16'h3f);

    // R10: unmapped address
    cycle(0, 0, 8'h80, 0);
    chk(rdata == 16'd0, "R10 unmapped", rdata, 0);

    // Random phase
    for (int k = 0; k < 4000; k++) begin
      r = $urandom % 5;
      p = (r == 0) ? 0 : (r == 1) ? 1 : (r == 2) ? 2 : (r == 3) ? 62 : 9;
      if (($urandom % 6) == 0) begin
        a = $urandom % 7;
        if (a == 0)      d = (($urandom % 4) == 0) ? 1 : 0;
        else if (a == 1) d = ((($urandom % 2) == 0) ? 62 : ($urandom % 4)) | (($urandom % 2) << 8);
        else if (a == 2) d = 4 + ($urandom % 30);
        else             d = $urandom % 36;
        cycle(p, 1, a, d);
      end else begin
        cycle(p, 0, $urandom % 7, 0);
      end
    end

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_err++; n_chk++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule